// File: doc/BRIEF.md
# Operand Store Buffer with Pairwise Age Ordering

This block holds up to eight pending operand stores between a processor's load/store port and a word-addressed memory write port. Each slot keeps one data word and a 16-bit tag. The tag is the 15-bit operand address with a physical flag above it. A store either lands in the slot whose tag already matches, or replaces the least recently used slot. A load that finds its address in a slot is answered from the buffer in the same cycle. A load that misses is flagged so the processor reads memory instead.

Recency is kept as a triangular matrix with one bit per unordered pair of slots. The oldest slot is the one that has lost every comparison. A slot leaves for memory only as a side effect of ageing: when the slot a store lands in was the oldest, the slot that becomes the new oldest is written back. The reserved physical addresses 1 to 7 do not hold data. A run of stores to them steps the buffer through a complete drain, one slot per store. Mapped tags go through a page-frame lookup supplied from outside. The lookup is done while the write-back is presented to memory.

Top module: `store_wbuf`

## Requirements
- R1: After reset every slot is empty (tag 0), the age matrix is zero, slot 0 is oldest, the drain step counter is 0, `reqReady` is 1 and `memWrValid` is 0.
- R2: Age bit for the pair (n,m) with n<m sits at n*(2*8-n-1)/2 + (m-n-1). A set bit means n is newer. Marking slot i newest sets all of its pairs with higher slots and clears all of its pairs with lower slots. The oldest slot is the lowest index whose higher-slot pairs are all 0 and whose lower-slot pairs are all 1.
- R3: The tag of a request is {reqPhys, reqAddr}, so a mapped and a physical access to the same 15-bit address are different entries. A store with reqAddr 0 changes nothing. A load with reqAddr 0 answers `rspHit`=1 with data 0.
- R4: A store whose tag matches a slot overwrites that slot's data and leaves the other slots unchanged.
- R5: A store that matches no slot goes into the current oldest slot. The chosen slot is then marked newest. If the chosen slot was the oldest, the oldest index is recomputed and the new oldest slot is written back.
- R6: A write-back of a slot whose tag is 0 produces no memory write. After a write-back the slot's tag is 0, so later loads of that address miss.
- R7: The write-back address of a tag with bit 15 set is its low 15 bits. For other tags it is {pfFrame, tag[9:0]}, with `pfPage` = tag[14:10].
- R8: A physical store (reqPhys=1) to an address from 1 to 7 is not buffered. It advances a saturating 4-bit step counter. At steps 1 to 8 it marks the oldest slot newest, recomputes the oldest and writes back the new oldest. At step 7 it then also zeroes the matrix and the oldest index. Every other non-zero store clears the counter.
- R9: A load whose tag matches a slot returns that slot's data with `rspHit`=1 in the request cycle. It marks the slot newest only if it is not the current oldest.
- R10: A load that matches no slot answers `rspValid`=1 with `rspHit`=0.
- R11: A write-back holds `memWrValid`, address and data steady until `memWrReady`. While it is pending, `reqReady` is 0 and no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 store, 0 load |
| reqPhys | input | 1 | Address is physical (mapping off) |
| reqAddr | input | 15 | Word address |
| reqData | input | 50 | Store word |
| reqReady | output | 1 | Request taken this cycle when high |
| rspValid | output | 1 | Load answered this cycle |
| rspHit | output | 1 | Load answered from the buffer |
| rspData | output | 50 | Buffered word for a hit |
| memWrValid | output | 1 | Write-back pending |
| memWrReady | input | 1 | Memory takes the write-back |
| memWrAddr | output | 15 | Physical write-back address |
| memWrData | output | 50 | Write-back word |
| pfPage | output | 5 | Page number to translate |
| pfFrame | input | 5 | Frame for `pfPage` |

## Verification
The hardest state to reach is a live slot that is also the oldest. Normal stores leave the oldest slot empty, because it has just been written back. Only the matrix clear at drain step 7 can make a full slot the oldest. That is the one case where a load hit must leave the ages alone, and where a matching store evicts a different live slot. The stimulus therefore mixes frequent runs of reserved-address stores into random traffic over a small address pool. This interrupts drains partway and refills the buffer after a clear. A reference model follows every age update, so the order of write-backs exposes any wrong age decision.

// File: rtl/store_wbuf_pkg.sv
package store_wbuf_pkg;
  // Strobes from the sequencing logic to the slot storage and the age matrix
  typedef struct packed {
    logic wrEntry;    // write tag and data into wrIdx
    logic touch;      // mark touchIdx newest
    logic updOldest;  // reload the oldest index from the updated matrix
    logic evict;      // write back the new oldest slot
    logic clearAge;   // zero matrix and oldest index
  } wb_strobe_t;
endpackage

// File: rtl/store_wbuf_age.sv
module store_wbuf_age #(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             touch,
  input  logic             updOldest,
  input  logic             clearAge,
  input  logic [IDX_W-1:0] touchIdx,
  output logic [IDX_W-1:0] oldest,
  output logic [IDX_W-1:0] nextOldest
);
  localparam int PAIRS = NUM_ENT * (NUM_ENT - 1) / 2;

  function automatic int pairPos(int n, int m);
    return n * (2 * NUM_ENT - n - 1) / 2 + (m - n - 1);
  endfunction

  function automatic logic [PAIRS-1:0] rowOf(int e);
    logic [PAIRS-1:0] v = '0;
    for (int o = e + 1; o < NUM_ENT; o++) v[pairPos(e, o)] = 1'b1;
    return v;
  endfunction

  function automatic logic [PAIRS-1:0] colOf(int e);
    logic [PAIRS-1:0] v = '0;
    for (int o = 0; o < e; o++) v[pairPos(o, e)] = 1'b1;
    return v;
  endfunction

  logic [PAIRS-1:0]   ageQ;
  logic [PAIRS-1:0]   ageNext;
  logic [PAIRS-1:0]   rowArr [NUM_ENT];
  logic [PAIRS-1:0]   colArr [NUM_ENT];
  logic [NUM_ENT-1:0] losesAll;

  for (genvar e = 0; e < NUM_ENT; e++) begin : gSlot
    localparam logic [PAIRS-1:0] ROW_M = rowOf(e);
    localparam logic [PAIRS-1:0] COL_M = colOf(e);
    assign rowArr[e]   = ROW_M;
    assign colArr[e]   = COL_M;
    assign losesAll[e] = ((ageNext & ROW_M) == '0) && ((ageNext & COL_M) == COL_M);
  end

  always_comb begin
    ageNext = ageQ;
    if (touch) ageNext = (ageQ & ~colArr[touchIdx]) | rowArr[touchIdx];
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    nextOldest = oldest;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (!found && losesAll[i]) begin
        nextOldest = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageQ   <= '0;
      oldest <= '0;
    end else if (clearAge) begin
      ageQ   <= '0;
      oldest <= '0;
    end else begin
      ageQ <= ageNext;
      if (updOldest) oldest <= nextOldest;
    end
  end

  // A slot just made newest can never be the oldest afterwards
  assert_touch_not_oldest_R2: assert property (@(posedge clk) disable iff (!rstN)
    (touch && !clearAge) |=> (oldest != $past(touchIdx)));
endmodule

// File: rtl/store_wbuf_dp.sv
module store_wbuf_dp #(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT),
  parameter int WORD_W  = 50,
  parameter int VADDR_W = 15,
  parameter int OFFS_W  = 10,
  parameter int FRAME_W = 5,
  parameter int TAG_W   = VADDR_W + 1,
  parameter int PAGE_W  = VADDR_W - OFFS_W,
  parameter int PADDR_W = (FRAME_W + OFFS_W > VADDR_W) ? FRAME_W + OFFS_W : VADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEntry,
  input  logic               evict,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   evictIdx,
  input  logic               keyValid,
  input  logic [TAG_W-1:0]   keyTag,
  input  logic [WORD_W-1:0]  wrData,
  output logic               hit,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [WORD_W-1:0]  hitData,
  output logic               wbPending,
  input  logic               memWrReady,
  output logic [PADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0]  memWrData,
  output logic [PAGE_W-1:0]  pfPage,
  input  logic [FRAME_W-1:0] pfFrame
);
  logic [TAG_W-1:0]   tagQ  [NUM_ENT];
  logic [WORD_W-1:0]  dataQ [NUM_ENT];
  logic [NUM_ENT-1:0] matchVec;
  logic [TAG_W-1:0]   wbTag;
  logic [WORD_W-1:0]  wbData;
  logic               victimLive;

  for (genvar i = 0; i < NUM_ENT; i++) begin : gEnt
    assign matchVec[i] = keyValid && (tagQ[i] == keyTag);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ[i]  <= '0;
        dataQ[i] <= '0;
      end else if (wrEntry && wrIdx == IDX_W'(i)) begin
        tagQ[i]  <= keyTag;
        dataQ[i] <= wrData;
      end else if (evict && evictIdx == IDX_W'(i)) begin
        tagQ[i]  <= '0;
      end
    end
  end

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (!hit && matchVec[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign hitData    = dataQ[hitIdx];
  assign victimLive = (tagQ[evictIdx] != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbPending <= 1'b0;
      wbTag     <= '0;
      wbData    <= '0;
    end else if (evict && victimLive) begin
      wbPending <= 1'b1;
      wbTag     <= tagQ[evictIdx];
      wbData    <= dataQ[evictIdx];
    end else if (memWrReady) begin
      wbPending <= 1'b0;
    end
  end

  // Translation happens while the write-back waits at the memory port
  assign pfPage    = wbTag[VADDR_W-1:OFFS_W];
  assign memWrData = wbData;
  assign memWrAddr = wbTag[VADDR_W] ? PADDR_W'(wbTag[VADDR_W-1:0])
                                    : PADDR_W'({pfFrame, wbTag[OFFS_W-1:0]});

  assert_unique_tag_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
  assert_wb_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wbPending && !memWrReady) |=> (wbPending && $stable(wbTag) && $stable(wbData)));
  assert_victim_differs_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEntry && evict) |-> (wrIdx != evictIdx));
endmodule

// File: rtl/store_wbuf_ctrl.sv
module store_wbuf_ctrl
  import store_wbuf_pkg::*;
#(
  parameter int NUM_ENT   = 8,
  parameter int IDX_W     = $clog2(NUM_ENT),
  parameter int VADDR_W   = 15,
  parameter int RSV_LIMIT = 8,
  parameter int TAG_W     = VADDR_W + 1,
  parameter int CNT_W     = $clog2(NUM_ENT + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               reqPhys,
  input  logic [VADDR_W-1:0] reqAddr,
  output logic               reqReady,
  output logic               rspValid,
  output logic               rspHit,
  output logic               rspZero,
  input  logic               wbPending,
  input  logic               hit,
  input  logic [IDX_W-1:0]   hitIdx,
  input  logic [IDX_W-1:0]   oldest,
  input  logic [IDX_W-1:0]   nextOldest,
  output wb_strobe_t         strb,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [IDX_W-1:0]   touchIdx,
  output logic [IDX_W-1:0]   evictIdx,
  output logic               keyValid,
  output logic [TAG_W-1:0]   keyTag
);
  logic [CNT_W-1:0] stepQ;
  logic isZero, accept, storeAcc, loadAcc, isReserved, drainAcc, plainStore, stepLive;

  assign isZero     = (reqAddr == '0);
  assign reqReady   = !wbPending;
  assign accept     = reqValid && reqReady;
  assign storeAcc   = accept && reqWrite && !isZero;
  assign loadAcc    = accept && !reqWrite && !isZero;
  assign isReserved = reqPhys && (reqAddr < VADDR_W'(RSV_LIMIT));
  assign drainAcc   = storeAcc && isReserved;
  assign plainStore = storeAcc && !isReserved;
  assign stepLive   = drainAcc && (stepQ >= CNT_W'(1)) && (stepQ <= CNT_W'(NUM_ENT));

  assign keyTag   = {reqPhys, reqAddr};
  assign keyValid = !isZero;
  assign wrIdx    = hit ? hitIdx : oldest;
  assign evictIdx = nextOldest;

  always_comb begin
    strb          = '0;
    touchIdx      = hitIdx;
    strb.wrEntry  = plainStore;
    if (plainStore) begin
      touchIdx       = wrIdx;
      strb.touch     = 1'b1;
      strb.updOldest = (wrIdx == oldest);
      strb.evict     = (wrIdx == oldest);
    end else if (stepLive) begin
      touchIdx       = oldest;
      strb.touch     = 1'b1;
      strb.updOldest = 1'b1;
      strb.evict     = 1'b1;
      strb.clearAge  = (stepQ == CNT_W'(NUM_ENT - 1));
    end else if (loadAcc && hit && hitIdx != oldest) begin
      strb.touch     = 1'b1;
    end
  end

  assign rspValid = accept && !reqWrite;
  assign rspZero  = isZero;
  assign rspHit   = isZero || hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          stepQ <= '0;
    else if (plainStore)                stepQ <= '0;
    else if (drainAcc && stepQ != '1)   stepQ <= stepQ + CNT_W'(1);
  end

  assert_wb_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbPending) |-> $past(reqValid && reqWrite && reqAddr != '0));
endmodule

// File: rtl/store_wbuf.sv
module store_wbuf
  import store_wbuf_pkg::*;
#(
  parameter int NUM_ENT   = 8,
  parameter int WORD_W    = 50,
  parameter int VADDR_W   = 15,
  parameter int OFFS_W    = 10,
  parameter int FRAME_W   = 5,
  parameter int RSV_LIMIT = 8,
  localparam int IDX_W    = $clog2(NUM_ENT),
  localparam int TAG_W    = VADDR_W + 1,
  localparam int PAGE_W   = VADDR_W - OFFS_W,
  localparam int PADDR_W  = (FRAME_W + OFFS_W > VADDR_W) ? FRAME_W + OFFS_W : VADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               reqPhys,
  input  logic [VADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0]  reqData,
  output logic               reqReady,
  output logic               rspValid,
  output logic               rspHit,
  output logic [WORD_W-1:0]  rspData,
  output logic               memWrValid,
  input  logic               memWrReady,
  output logic [PADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0]  memWrData,
  output logic [PAGE_W-1:0]  pfPage,
  input  logic [FRAME_W-1:0] pfFrame
);
  wb_strobe_t       strb;
  logic [IDX_W-1:0] wrIdx, touchIdx, evictIdx, hitIdx, oldest, nextOldest;
  logic [TAG_W-1:0] keyTag;
  logic [WORD_W-1:0] hitData;
  logic keyValid, hit, rspZero;

  store_wbuf_ctrl #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .VADDR_W(VADDR_W),
                    .RSV_LIMIT(RSV_LIMIT), .TAG_W(TAG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhys(reqPhys), .reqAddr(reqAddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspHit(rspHit), .rspZero(rspZero),
    .wbPending(memWrValid), .hit(hit), .hitIdx(hitIdx), .oldest(oldest),
    .nextOldest(nextOldest), .strb(strb), .wrIdx(wrIdx), .touchIdx(touchIdx),
    .evictIdx(evictIdx), .keyValid(keyValid), .keyTag(keyTag));

  store_wbuf_age #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) age_i (
    .clk(clk), .rstN(rstN), .touch(strb.touch), .updOldest(strb.updOldest),
    .clearAge(strb.clearAge), .touchIdx(touchIdx), .oldest(oldest),
    .nextOldest(nextOldest));

  store_wbuf_dp #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .WORD_W(WORD_W),
                  .VADDR_W(VADDR_W), .OFFS_W(OFFS_W), .FRAME_W(FRAME_W),
                  .TAG_W(TAG_W), .PAGE_W(PAGE_W), .PADDR_W(PADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrEntry(strb.wrEntry), .evict(strb.evict),
    .wrIdx(wrIdx), .evictIdx(evictIdx), .keyValid(keyValid), .keyTag(keyTag),
    .wrData(reqData), .hit(hit), .hitIdx(hitIdx), .hitData(hitData),
    .wbPending(memWrValid), .memWrReady(memWrReady), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .pfPage(pfPage), .pfFrame(pfFrame));

  assign rspData = rspZero ? '0 : hitData;
endmodule

// File: tb/store_wbuf_tb.sv
module store_wbuf_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqPhys = 0, memWrReady = 0;
  logic [14:0] reqAddr = '0;
  logic [49:0] reqData = '0;
  logic reqReady, rspValid, rspHit, memWrValid;
  logic [49:0] rspData, memWrData;
  logic [14:0] memWrAddr;
  logic [4:0]  pfPage, pfFrame;

  always #4 clk = ~clk;  // 125 MHz
  assign pfFrame = pfPage ^ 5'h13;

  store_wbuf dut_i (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhys(reqPhys), .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData), .memWrValid(memWrValid),
    .memWrReady(memWrReady), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .pfPage(pfPage), .pfFrame(pfFrame));

  int nChecks = 0, nErrors = 0;
  bit finished = 0;

  // Reference state built from the requirements
  logic [15:0] mTag [8];
  logic [49:0] mData [8];
  logic [27:0] mMat;
  int mOld, mCnt;
  bit expWb;
  logic [14:0] expA;
  logic [49:0] expD;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pos(int n, int m);
    return n * (15 - n) / 2 + (m - n - 1);
  endfunction
  function automatic logic [27:0] mRow(int e);
    logic [27:0] v = '0;
    for (int o = e + 1; o < 8; o++) v[pos(e, o)] = 1'b1;
    return v;
  endfunction
  function automatic logic [27:0] mCol(int e);
    logic [27:0] v = '0;
    for (int o = 0; o < e; o++) v[pos(o, e)] = 1'b1;
    return v;
  endfunction
  function automatic int oldestOf(logic [27:0] m, int dflt);
    for (int i = 0; i < 8; i++)
      if ((m & mRow(i)) == '0 && (m & mCol(i)) == mCol(i)) return i;
    return dflt;
  endfunction
  function automatic logic [14:0] xlate(logic [15:0] t);
    return t[15] ? t[14:0] : {t[14:10] ^ 5'h13, t[9:0]};
  endfunction
  function automatic int findTag(logic [15:0] k);
    for (int i = 0; i < 8; i++) if (mTag[i] == k) return i;
    return -1;
  endfunction

  task automatic mTouch(int i);
    mMat = (mMat & ~mCol(i)) | mRow(i);
  endtask
  task automatic mEvict(int v);
    if (mTag[v] != 16'h0) begin
      expWb = 1; expA = xlate(mTag[v]); expD = mData[v]; mTag[v] = 16'h0;
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin mTag[i] = '0; mData[i] = '0; end
    mMat = '0; mOld = 0; mCnt = 0;
  endtask

  task automatic modelStep(bit wr, bit ph, logic [14:0] a, logic [49:0] d);
    logic [15:0] key;
    int j;
    key = {ph, a};
    expWb = 0;
    if (a == 15'h0) return;
    if (wr) begin
      if (ph && a < 15'd8) begin
        if (mCnt >= 1 && mCnt <= 8) begin
          mTouch(mOld);
          mOld = oldestOf(mMat, mOld);
          mEvict(mOld);
          if (mCnt == 7) begin mMat = '0; mOld = 0; end
        end
        if (mCnt < 15) mCnt++;
      end else begin
        mCnt = 0;
        j = findTag(key);
        if (j < 0) j = mOld;
        mTag[j] = key; mData[j] = d;
        mTouch(j);
        if (j == mOld) begin
          mOld = oldestOf(mMat, mOld);
          mEvict(mOld);
        end
      end
    end else begin
      j = findTag(key);
      if (j >= 0 && j != mOld) mTouch(j);
    end
  endtask

  task automatic doOp(input bit wr, input bit ph, input logic [14:0] a, input logic [49:0] d,
                      output bit oHit, output logic [49:0] oData,
                      output bit oWb, output logic [14:0] oWbAddr);
    int j, tries;
    bit done;
    string tg;
    oHit = 0; oData = '0;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqPhys = ph; reqAddr = a; reqData = d;
    #1;
    if (!wr) begin
      j = findTag({ph, a});
      tg = (a == 0) ? "R3" : (j >= 0) ? "R9" : "R10";
      chk(rspValid === 1'b1, tg, "rspValid", 64'(rspValid), 64'd1);
      chk(rspHit === (a == 0 || j >= 0), tg, "rspHit", 64'(rspHit), 64'(a == 0 || j >= 0));
      if (a == 0) chk(rspData === '0, "R3", "zero load data", 64'(rspData), 64'd0);
      else if (j >= 0) chk(rspData === mData[j], "R9", "hit data", 64'(rspData), 64'(mData[j]));
      oHit = rspHit; oData = rspData;
    end
    @(posedge clk);
    modelStep(wr, ph, a, d);
    #1 reqValid = 0;
    @(negedge clk);
    oWb = memWrValid; oWbAddr = memWrAddr;
    if (expWb) begin
      tg = (ph && a < 15'd8) ? "R8" : "R5";
      chk(memWrValid === 1'b1, tg, "write-back present", 64'(memWrValid), 64'd1);
      chk(memWrAddr === expA, "R7", "write-back address", 64'(memWrAddr), 64'(expA));
      chk(memWrData === expD, tg, "write-back data", 64'(memWrData), 64'(expD));
      chk(reqReady === 1'b0, "R11", "stall while pending", 64'(reqReady), 64'd0);
      done = 0; tries = 0;
      while (!done) begin
        memWrReady = (tries >= 3) ? 1'b1 : 1'($urandom % 2);
        tries++;
        @(posedge clk);
        done = memWrReady;
        #1 memWrReady = 0;
        @(negedge clk);
        if (!done)
          chk(memWrValid === 1'b1 && memWrAddr === expA, "R11", "hold until ready",
              64'(memWrAddr), 64'(expA));
        else
          chk(memWrValid === 1'b0 && reqReady === 1'b1, "R11", "release after ready",
              64'({memWrValid, reqReady}), 64'b01);
      end
    end else begin
      chk(memWrValid === 1'b0, "R6", "no write-back", 64'(memWrValid), 64'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nErrors++; nChecks++;
      $display("FAIL R11 watchdog expired: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    bit h, w;
    logic [49:0] dd;
    logic [14:0] wa;
    logic [14:0] pool [8];
    void'($urandom(32'd7315));
    modelReset();
    for (int k = 0; k < 8; k++) pool[k] = 15'(32'h0400 * k + 32'h10 + k);
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1;
    #1;
    chk(reqReady === 1'b1, "R1", "ready after reset", 64'(reqReady), 64'd1);
    chk(memWrValid === 1'b0, "R1", "no write after reset", 64'(memWrValid), 64'd0);
    chk(rspValid === 1'b0, "R1", "no response idle", 64'(rspValid), 64'd0);
    doOp(0, 0, pool[2], '0, h, dd, w, wa);
    chk(h == 0, "R1", "empty buffer load", 64'(h), 64'd0);

    // Fill: the eighth distinct store writes back the first one
    for (int k = 0; k < 8; k++) begin
      doOp(1, 0, pool[k], 50'(64'hA000 + k), h, dd, w, wa);
      if (k == 7)
        chk(w && wa == xlate({1'b0, pool[0]}), "R2", "eighth store evicts first",
            64'(wa), 64'(xlate({1'b0, pool[0]})));
    end
    // Overwrite on match
    doOp(1, 0, pool[3], 50'h3_1234_5678, h, dd, w, wa);
    chk(w == 0, "R4", "store hit writes nothing back", 64'(w), 64'd0);
    doOp(0, 0, pool[3], '0, h, dd, w, wa);
    chk(h && dd == 50'h3_1234_5678, "R4", "overwritten data", 64'(dd), 64'h3_1234_5678);
    // Physical flag separates entries; address 0 ignored
    doOp(0, 1, pool[3], '0, h, dd, w, wa);
    chk(h == 0, "R3", "physical alias misses", 64'(h), 64'd0);
    doOp(1, 0, 15'h0, 50'h1F, h, dd, w, wa);
    doOp(0, 0, 15'h0, '0, h, dd, w, wa);
    chk(h && dd == '0, "R3", "address zero load", 64'(dd), 64'd0);
    // Full drain through the reserved addresses
    for (int s = 0; s < 10; s++) doOp(1, 1, 15'(1 + s % 7), '0, h, dd, w, wa);
    for (int k = 1; k < 8; k++) begin
      doOp(0, 0, pool[k], '0, h, dd, w, wa);
      chk(h == 0, "R8", "drained slot misses", 64'(h), 64'd0);
    end
    // Random traffic with interrupted drains
    for (int n = 0; n < 1500; n++) begin
      int r;
      bit ph;
      logic [14:0] a;
      r  = int'($urandom % 100);
      ph = ($urandom % 4) == 0;
      a  = pool[$urandom % 8];
      if (r < 14) doOp(1, 1, 15'(1 + $urandom % 7), '0, h, dd, w, wa);
      else if (r < 18) doOp(r[0], ph, 15'h0, 50'h2A, h, dd, w, wa);
      else if (r < 60) doOp(1, ph, a, {18'($urandom), 32'($urandom)}, h, dd, w, wa);
      else doOp(0, ph, a, '0, h, dd, w, wa);
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule